// File: doc/BRIEF.md
# Byte-Wide EEPROM Program/Erase Sequencer

This block holds a small non-volatile byte array together with the control logic that a processor uses to change it. The array is never written in one step. Software first sets a latch-enable bit in the program-control register and writes one byte to the array. This captures a target address and a data byte. It then raises a program-voltage bit, waits at least a minimum number of clock cycles, and lowers that bit again. On that falling edge the stored contents change. The mode bits pick what the change does: clear bits under the latched byte, erase that byte, erase the aligned row of `ROW_BYTES` bytes that holds it, or erase the whole storage.

One extra byte sits just past the array and is reached only through a separate configuration register strobe. Its stored value is copied into the live configuration register during reset. Bit 0 of the live configuration register decides whether the array answers on its address window, so an edit to the configuration byte only takes effect after the next reset. Misuse of the protocol raises a one-cycle error pulse, registered, in the cycle after the offending access. While the CPU-running input is low, array and configuration writes go straight into storage, which serves as a debug and initialisation path.

Top module: `eeprom_seq_ctrl`

## Requirements
- R1: After reset the program-control register reads 0x00, the live configuration register equals the stored configuration byte, and `arrMapped` equals its bit 0.
- R2: Program-control layout: bit 0 program voltage, bit 1 latch enable, bit 2 erase, bit 3 row, bit 4 byte; bits 7..5 always read zero. A control write with bit 1 clear stores 0x00.
- R3: A control write that raises bit 0 and bit 1 together pulses `errBothSet` and leaves the register unchanged. Clearing both together is legal and raises no error.
- R4: Raising bit 0 while no address/data pair is latched pulses `errNoAddr`. The bit is still stored, but its falling edge changes no storage.
- R5: While running, a mapped array write or a configuration write with latch enable clear pulses `errWrOff` and is ignored. A second write while a pair is already latched pulses `errDoubleLatch`, and the first pair is kept.
- R6: With bit 2 clear, the falling edge of bit 0 ANDs the latched byte into the latched location, so bits only go from 1 to 0.
- R7: With bit 2 set and bit 4 set, the falling edge sets only the latched location to 0xFF. When the latched target is the configuration byte, any erase acts as a byte erase of that byte alone.
- R8: With bits 2 and 3 set and bit 4 clear, the falling edge sets to 0xFF all array bytes whose index matches the latched index with its low log2(`ROW_BYTES`) bits ignored.
- R9: With bit 2 set and bits 3 and 4 clear, the falling edge sets every array byte and the configuration byte to 0xFF.
- R10: If fewer than `MIN_PULSE` clock edges separate the rising and falling control writes of bit 0, `errShortPulse` pulses. The commit still happens. Exactly `MIN_PULSE` edges raises no error.
- R11: A running read of the mapped array while latch enable is set pulses `errRdBusy`.
- R12: Configuration writes target the storage byte at index `MEM_BYTES`, which is not visible in the array window. `arrMapped` changes only at reset. While unmapped, `rdData` is 0x00 and array writes are ignored.
- R13: With `cpuRunning` low, an array or configuration write stores its byte directly, with no latch or pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cpuRunning | input | 1 | High for normal accesses, low for direct debug writes |
| ctlWr | input | 1 | Write strobe for the program-control register |
| cfgWr | input | 1 | Write strobe for the configuration register address |
| arrWr | input | 1 | Write strobe for the array window |
| arrRd | input | 1 | Read strobe for the array window |
| arrAddr | input | ADDR_W | Array byte index |
| wrData | input | 8 | Write data for all strobes |
| rdData | output | 8 | Array byte at arrAddr, 0x00 when unmapped |
| ctlReg | output | 8 | Program-control register |
| cfgReg | output | 8 | Live configuration register |
| arrMapped | output | 1 | Array window enabled |
| errBothSet | output | 1 | Latch and voltage raised together |
| errNoAddr | output | 1 | Voltage raised with nothing latched |
| errShortPulse | output | 1 | Voltage pulse below minimum length |
| errWrOff | output | 1 | Write with latch enable clear |
| errDoubleLatch | output | 1 | Write while a pair is already latched |
| errRdBusy | output | 1 | Read during programming |

## Verification
The bench builds the block with a 64-byte array, 16-byte rows, a 40-cycle minimum pulse and a 16-bit cycle counter. The short pulse puts the pulse-length boundary, at exactly the minimum and one below it, within a few dozen cycles. The small array keeps row and bulk erases cheap to observe at both ends, and still gives four distinct rows, so an erase that spills over a row boundary is caught.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;
  // program-control bit positions
  localparam int BIT_PGM   = 0;
  localparam int BIT_LAT   = 1;
  localparam int BIT_ERASE = 2;
  localparam int BIT_ROW   = 3;
  localparam int BIT_BYTE  = 4;
  localparam logic [7:0] CTL_MASK = 8'h1F;
  // configuration bit that enables the array window
  localparam int BIT_MAP = 0;

  typedef struct packed {
    logic dbgWr;
    logic progOp;
    logic eraseByte;
    logic eraseRow;
    logic eraseAll;
  } memOpT;
endpackage

// File: rtl/eeprom_seq_ctl.sv
module eeprom_seq_ctl
  import eeprom_seq_pkg::*;
#(
  parameter int MEM_BYTES = 512,
  parameter int MIN_PULSE = 10000,
  parameter int CNT_W     = 24,
  localparam int ADDR_W   = $clog2(MEM_BYTES),
  localparam int IDX_W    = $clog2(MEM_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuRunning,
  input  logic              ctlWr,
  input  logic              cfgWr,
  input  logic              arrWr,
  input  logic              arrRd,
  input  logic [ADDR_W-1:0] arrAddr,
  input  logic [7:0]        wrData,
  input  logic              mapped,
  output logic [7:0]        ctlReg,
  output memOpT             memOp,
  output logic [IDX_W-1:0]  tgtIdx,
  output logic [7:0]        tgtData,
  output logic              errBothSet,
  output logic              errNoAddr,
  output logic              errShortPulse,
  output logic              errWrOff,
  output logic              errDoubleLatch,
  output logic              errRdBusy
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MEM_BYTES);
  localparam logic [CNT_W-1:0] MIN_CNT  = CNT_W'(MIN_PULSE);

  logic [CNT_W-1:0] cycCnt, startCnt, elapsed;
  logic             latched;
  logic [IDX_W-1:0] latIdx, wrIdx;
  logic [7:0]       latData, riseBits, nextCtl;
  logic             bothRise, ctlTake, pgmOn, pgmOff, wrReq, commit;

  always_comb begin
    riseBits = (ctlReg ^ wrData) & wrData;
    bothRise = riseBits[BIT_LAT] && riseBits[BIT_PGM];
    nextCtl  = wrData[BIT_LAT] ? (wrData & CTL_MASK) : 8'h00;
    ctlTake  = ctlWr && !bothRise;
    pgmOn    = ctlTake && nextCtl[BIT_PGM] && !ctlReg[BIT_PGM];
    pgmOff   = ctlTake && !nextCtl[BIT_PGM] && ctlReg[BIT_PGM];
    commit   = pgmOff && latched;
    elapsed  = cycCnt - startCnt;
    wrIdx    = cfgWr ? LAST_IDX : IDX_W'(arrAddr);
    wrReq    = !ctlWr && (cfgWr || (arrWr && mapped));
  end

  always_comb begin
    memOp   = '0;
    tgtIdx  = latIdx;
    tgtData = latData;
    if (wrReq && !cpuRunning) begin
      memOp.dbgWr = 1'b1;
      tgtIdx      = wrIdx;
      tgtData     = wrData;
    end else if (commit) begin
      if (!ctlReg[BIT_ERASE])                          memOp.progOp    = 1'b1;
      else if (ctlReg[BIT_BYTE] || latIdx == LAST_IDX) memOp.eraseByte = 1'b1;
      else if (ctlReg[BIT_ROW])                        memOp.eraseRow  = 1'b1;
      else                                             memOp.eraseAll  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycCnt         <= '0;
      startCnt       <= '0;
      ctlReg         <= 8'h00;
      latched        <= 1'b0;
      latIdx         <= '0;
      latData        <= 8'h00;
      errBothSet     <= 1'b0;
      errNoAddr      <= 1'b0;
      errShortPulse  <= 1'b0;
      errWrOff       <= 1'b0;
      errDoubleLatch <= 1'b0;
      errRdBusy      <= 1'b0;
    end else begin
      cycCnt         <= cycCnt + 1'b1;
      errBothSet     <= ctlWr && bothRise;
      errNoAddr      <= pgmOn && !latched;
      errShortPulse  <= commit && (elapsed < MIN_CNT);
      errWrOff       <= wrReq && cpuRunning && !ctlReg[BIT_LAT];
      errDoubleLatch <= wrReq && cpuRunning && ctlReg[BIT_LAT] && latched;
      errRdBusy      <= arrRd && mapped && cpuRunning && ctlReg[BIT_LAT];
      if (ctlTake) ctlReg <= nextCtl;
      if (pgmOn)   startCnt <= cycCnt;
      if (pgmOff) begin
        latched <= 1'b0;
      end else if (wrReq && cpuRunning && ctlReg[BIT_LAT] && !latched) begin
        latched <= 1'b1;
        latIdx  <= wrIdx;
        latData <= wrData;
      end
    end
  end

  // R3
  both_rise_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && wrData[BIT_LAT] && wrData[BIT_PGM] && !ctlReg[BIT_LAT] && !ctlReg[BIT_PGM])
      |=> ($stable(ctlReg) && errBothSet));
  // R4
  no_addr_pgm_chk: assert property (@(posedge clk) disable iff (!rstN)
    errNoAddr |-> ctlReg[BIT_PGM]);
  // R5
  write_refused_chk: assert property (@(posedge clk) disable iff (!rstN)
    (arrWr && mapped && cpuRunning && !ctlWr && !ctlReg[BIT_LAT]) |=> (errWrOff && !latched));
  // R11
  read_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (arrRd && mapped && cpuRunning && ctlReg[BIT_LAT]) |=> errRdBusy);
  // R2
  ctl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlReg[7:5] == 3'b000);
endmodule

// File: rtl/eeprom_seq_store.sv
module eeprom_seq_store
  import eeprom_seq_pkg::*;
#(
  parameter int MEM_BYTES = 512,
  parameter int ROW_BYTES = 16,
  localparam int ADDR_W   = $clog2(MEM_BYTES),
  localparam int IDX_W    = $clog2(MEM_BYTES + 1),
  localparam int ROW_SH   = $clog2(ROW_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  memOpT             memOp,
  input  logic [IDX_W-1:0]  tgtIdx,
  input  logic [7:0]        tgtData,
  input  logic [ADDR_W-1:0] arrAddr,
  output logic [7:0]        rdData,
  output logic [7:0]        cfgReg,
  output logic              mapped
);
  logic [7:0] cells [0:MEM_BYTES];

  for (genvar g = 0; g <= MEM_BYTES; g++) begin : gCell
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    localparam bit IS_CFG = (g == MEM_BYTES);
    logic [7:0] cellQ;
    logic       hit, inRow;
    assign hit   = (tgtIdx == MY_IDX);
    assign inRow = !IS_CFG && (tgtIdx[IDX_W-1:ROW_SH] == MY_IDX[IDX_W-1:ROW_SH]);
    always_ff @(posedge clk) begin
      if (memOp.eraseAll)                 cellQ <= 8'hFF;
      else if (memOp.eraseRow && inRow)   cellQ <= 8'hFF;
      else if (hit && memOp.dbgWr)        cellQ <= tgtData;
      else if (hit && memOp.progOp)       cellQ <= cellQ & tgtData;
      else if (hit && memOp.eraseByte)    cellQ <= 8'hFF;
    end
    assign cells[g] = cellQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cfgReg <= cells[MEM_BYTES];
  end

  assign mapped = cfgReg[BIT_MAP];
  assign rdData = mapped ? cells[arrAddr] : 8'h00;

  // R12
  map_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(mapped));
  // R12
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> (rdData == 8'h00));
endmodule

// File: rtl/eeprom_seq_ctrl.sv
module eeprom_seq_ctrl
  import eeprom_seq_pkg::*;
#(
  parameter int MEM_BYTES = 512,
  parameter int ROW_BYTES = 16,
  parameter int MIN_PULSE = 10000,
  parameter int CNT_W     = 24,
  localparam int ADDR_W   = $clog2(MEM_BYTES),
  localparam int IDX_W    = $clog2(MEM_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuRunning,
  input  logic              ctlWr,
  input  logic              cfgWr,
  input  logic              arrWr,
  input  logic              arrRd,
  input  logic [ADDR_W-1:0] arrAddr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic [7:0]        ctlReg,
  output logic [7:0]        cfgReg,
  output logic              arrMapped,
  output logic              errBothSet,
  output logic              errNoAddr,
  output logic              errShortPulse,
  output logic              errWrOff,
  output logic              errDoubleLatch,
  output logic              errRdBusy
);
  memOpT            memOp;
  logic [IDX_W-1:0] tgtIdx;
  logic [7:0]       tgtData;

  eeprom_seq_ctl #(
    .MEM_BYTES(MEM_BYTES), .MIN_PULSE(MIN_PULSE), .CNT_W(CNT_W)
  ) uCtl (
    .clk(clk), .rstN(rstN), .cpuRunning(cpuRunning),
    .ctlWr(ctlWr), .cfgWr(cfgWr), .arrWr(arrWr), .arrRd(arrRd),
    .arrAddr(arrAddr), .wrData(wrData), .mapped(arrMapped),
    .ctlReg(ctlReg), .memOp(memOp), .tgtIdx(tgtIdx), .tgtData(tgtData),
    .errBothSet(errBothSet), .errNoAddr(errNoAddr), .errShortPulse(errShortPulse),
    .errWrOff(errWrOff), .errDoubleLatch(errDoubleLatch), .errRdBusy(errRdBusy)
  );

  eeprom_seq_store #(
    .MEM_BYTES(MEM_BYTES), .ROW_BYTES(ROW_BYTES)
  ) uStore (
    .clk(clk), .rstN(rstN), .memOp(memOp), .tgtIdx(tgtIdx), .tgtData(tgtData),
    .arrAddr(arrAddr), .rdData(rdData), .cfgReg(cfgReg), .mapped(arrMapped)
  );
endmodule

// File: tb/tb_eeprom_seq_ctrl.sv
module tb_eeprom_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int MEM  = 64;
  localparam int ROWB = 16;
  localparam int MINP = 40;
  localparam int AW   = $clog2(MEM);

  logic clk = 1'b0, rstN = 1'b0, cpuRunning = 1'b0;
  logic ctlWr = 1'b0, cfgWr = 1'b0, arrWr = 1'b0, arrRd = 1'b0;
  logic [AW-1:0] arrAddr = '0;
  logic [7:0] wrData = 8'h00, rdData, ctlReg, cfgReg;
  logic arrMapped, errBothSet, errNoAddr, errShortPulse, errWrOff, errDoubleLatch, errRdBusy;
  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [5:0] errCap;
  logic [7:0] rdCap;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_seq_ctrl #(.MEM_BYTES(MEM), .ROW_BYTES(ROWB), .MIN_PULSE(MINP), .CNT_W(16)) dut (
    .clk(clk), .rstN(rstN), .cpuRunning(cpuRunning), .ctlWr(ctlWr), .cfgWr(cfgWr),
    .arrWr(arrWr), .arrRd(arrRd), .arrAddr(arrAddr), .wrData(wrData), .rdData(rdData),
    .ctlReg(ctlReg), .cfgReg(cfgReg), .arrMapped(arrMapped), .errBothSet(errBothSet),
    .errNoAddr(errNoAddr), .errShortPulse(errShortPulse), .errWrOff(errWrOff),
    .errDoubleLatch(errDoubleLatch), .errRdBusy(errRdBusy));

  // error bit order in errCap
  localparam int E_BOTH = 5, E_NOADDR = 4, E_SHORT = 3, E_WROFF = 2, E_DOUBLE = 1, E_RDBUSY = 0;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) ^ 8'hA0);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic capErr();
    errCap = {errBothSet, errNoAddr, errShortPulse, errWrOff, errDoubleLatch, errRdBusy};
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic doCtl(input logic [7:0] v);
    ctlWr = 1'b1; wrData = v;
    @(negedge clk);
    ctlWr = 1'b0; capErr();
  endtask

  task automatic doArrWr(input int a, input logic [7:0] d);
    arrWr = 1'b1; arrAddr = AW'(a); wrData = d;
    @(negedge clk);
    arrWr = 1'b0; capErr();
  endtask

  task automatic doCfgWr(input logic [7:0] d);
    cfgWr = 1'b1; wrData = d;
    @(negedge clk);
    cfgWr = 1'b0; capErr();
  endtask

  task automatic doRead(input int a);
    arrRd = 1'b1; arrAddr = AW'(a);
    @(negedge clk);
    rdCap = rdData; arrRd = 1'b0; capErr();
  endtask

  // raise voltage, hold so that 'hold' clock edges separate the two writes, lower it
  task automatic pulse(input logic [7:0] mode, input int hold);
    doCtl(mode | 8'h03);
    repeat (hold - 1) @(negedge clk);
    doCtl(mode | 8'h02);
  endtask

  task automatic tInit();
    cpuRunning = 1'b0;
    doReset();
    doCfgWr(8'hFF);
    doReset();
    chk("R1 ctlReg after reset", ctlReg, 8'h00);
    chk("R1 cfgReg loaded", cfgReg, 8'hFF);
    chk("R1 mapped", arrMapped, 1'b1);
    for (int a = 0; a < MEM; a++) doArrWr(a, pat(a));
    doRead(5);
    chk("R13 debug write", rdCap, pat(5));
    cpuRunning = 1'b1;
  endtask

  task automatic tCtlMask();
    doCtl(8'hE6);
    chk("R2 upper bits zero", ctlReg, 8'h06);
    doCtl(8'h1C);
    chk("R2 latch clear zeroes", ctlReg, 8'h00);
  endtask

  task automatic tBothRise();
    doCtl(8'h03);
    chk("R3 error flag", errCap[E_BOTH], 1'b1);
    chk("R3 register unchanged", ctlReg, 8'h00);
    doCtl(8'h02);
    doCtl(8'h00);
    chk("R3 clearing both legal", errCap, 6'b0);
    chk("R3 cleared", ctlReg, 8'h00);
  endtask

  task automatic tNoAddr();
    doCtl(8'h02);
    doCtl(8'h03);
    chk("R4 no address flag", errCap[E_NOADDR], 1'b1);
    chk("R4 bit stored", ctlReg, 8'h03);
    doCtl(8'h02);
    doCtl(8'h00);
    doRead(0);
    chk("R4 no storage change", rdCap, pat(0));
  endtask

  task automatic tWrOff();
    doArrWr(1, 8'h00);
    chk("R5 write without latch enable", errCap[E_WROFF], 1'b1);
    doRead(1);
    chk("R5 write ignored", rdCap, pat(1));
  endtask

  task automatic tProgram();
    doCtl(8'h02);
    doArrWr(2, 8'h0F);
    chk("R5 first latch clean", errCap, 6'b0);
    doArrWr(3, 8'h00);
    chk("R5 double latch flag", errCap[E_DOUBLE], 1'b1);
    pulse(8'h00, MINP);
    chk("R10 exact minimum no error", errCap, 6'b0);
    doCtl(8'h00);
    doRead(2);
    chk("R6 AND commit", rdCap, pat(2) & 8'h0F);
    doRead(3);
    chk("R5 second pair dropped", rdCap, pat(3));
    doCtl(8'h02);
    doArrWr(2, 8'hFF);
    pulse(8'h00, MINP);
    doCtl(8'h00);
    doRead(2);
    chk("R6 bits never set", rdCap, pat(2) & 8'h0F);
  endtask

  task automatic tReadBusy();
    doCtl(8'h02);
    doRead(4);
    chk("R11 read while latched", errCap[E_RDBUSY], 1'b1);
    doCtl(8'h00);
    doRead(4);
    chk("R11 normal read clean", errCap[E_RDBUSY], 1'b0);
    chk("R11 normal read data", rdCap, pat(4));
  endtask

  task automatic tShort();
    doCtl(8'h02);
    doArrWr(5, 8'h00);
    pulse(8'h00, MINP - 1);
    chk("R10 short pulse flag", errCap[E_SHORT], 1'b1);
    doCtl(8'h00);
    doRead(5);
    chk("R10 commit still done", rdCap, 8'h00);
  endtask

  task automatic tByteErase();
    doCtl(8'h16);
    doArrWr(2, 8'h00);
    pulse(8'h14, MINP);
    doCtl(8'h00);
    doRead(2);
    chk("R7 byte erased", rdCap, 8'hFF);
    doRead(3);
    chk("R7 neighbour kept", rdCap, pat(3));
  endtask

  task automatic tRowErase();
    doCtl(8'h0E);
    doArrWr(19, 8'h00);
    pulse(8'h0C, MINP);
    doCtl(8'h00);
    doRead(15); chk("R8 row below kept", rdCap, pat(15));
    doRead(16); chk("R8 row start erased", rdCap, 8'hFF);
    doRead(31); chk("R8 row end erased", rdCap, 8'hFF);
    doRead(32); chk("R8 row above kept", rdCap, pat(32));
  endtask

  task automatic tConfig();
    doCtl(8'h02);
    doCfgWr(8'h5D);
    pulse(8'h00, MINP);
    doCtl(8'h00);
    chk("R12 live config unchanged before reset", cfgReg, 8'hFF);
    doReset();
    chk("R12 config after reset", cfgReg, 8'h5D);
    chk("R1 mapped follows bit0", arrMapped, 1'b1);
    doCtl(8'h06);
    doCfgWr(8'h00);
    pulse(8'h04, MINP);
    doCtl(8'h00);
    doRead(0);
    chk("R7 config erase spares array", rdCap, pat(0));
    doReset();
    chk("R7 config byte erased", cfgReg, 8'hFF);
  endtask

  task automatic tUnmapped();
    cpuRunning = 1'b0;
    doCfgWr(8'h80);
    doReset();
    cpuRunning = 1'b1;
    chk("R12 unmapped after reset", arrMapped, 1'b0);
    doRead(0);
    chk("R12 unmapped read zero", rdCap, 8'h00);
    doCtl(8'h02);
    doArrWr(0, 8'h00);
    chk("R12 unmapped write no error", errCap, 6'b0);
    doCtl(8'h03);
    chk("R12 unmapped write not latched", errCap[E_NOADDR], 1'b1);
    doCtl(8'h02);
    doCtl(8'h00);
    cpuRunning = 1'b0;
    doCfgWr(8'hFF);
    doReset();
    cpuRunning = 1'b1;
    doRead(0);
    chk("R12 unmapped write ignored", rdCap, pat(0));
  endtask

  task automatic tBulk();
    cpuRunning = 1'b0;
    doCfgWr(8'h81);
    doReset();
    cpuRunning = 1'b1;
    chk("R1 config reload", cfgReg, 8'h81);
    doCtl(8'h06);
    doArrWr(7, 8'h00);
    pulse(8'h04, MINP);
    doCtl(8'h00);
    doRead(0);       chk("R9 first byte erased", rdCap, 8'hFF);
    doRead(MEM - 1); chk("R9 last byte erased", rdCap, 8'hFF);
    doReset();
    chk("R9 config byte erased", cfgReg, 8'hFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tInit();
    tCtlMask();
    tBothRise();
    tNoAddr();
    tWrOff();
    tProgram();
    tReadBusy();
    tShort();
    tByteErase();
    tRowErase();
    tConfig();
    tUnmapped();
    tBulk();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule